// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the bus-facing control and status logic that sits in front of a SHA-1/MD5 compression engine. A host reads and writes 32-bit registers on a simple byte-addressed bus. It programs a chunk length and the per-chunk flags through a control word, then feeds up to sixteen data words through a fixed-address input window. The block counts the words against the programmed length. It hands the filled chunk to the engine over a valid/ready stream, waits for the engine's result and folds that result back into the digest and byte-count registers. It then raises output-ready and, when enabled, a level interrupt.

The digest and byte-count registers stay writable while no chunk is in flight. Software can therefore save the context of one message, run another and restore the first before its next chunk. A DMA request line lets a DMA channel fill the window with a burst to one address. A self-timed soft reset returns every piece of state to its initial value. Back-pressure on the chunk stream is the engine's: once `chunk_valid` rises, the chunk data, length and flags hold still until the cycle in which `chunk_ready` is high. The result path has no ready; the block accepts `res_valid` only while it waits for a result and ignores it otherwise.

Top module: `sham_regs`

## Requirements
- R1: After a power-on reset the control word, byte count and digest read 0, and bit 0 of the status register (offset 0x64) reads 1.
- R2: Offsets not in the map (anything other than 0x00-0x10, 0x14, 0x18, 0x1C-0x58, 0x5C, 0x60 and 0x64 on word boundaries) read as 0, and writes to them change no register.
- R3: Writing a nonzero byte length into control bits [31:5] arms a chunk. Control bit 1 (input-ready) then reads 1 until ceil(length/4) window words have been written, and lengths above 64 are treated as 64 bytes and 16 words.
- R4: A filled chunk is offered with `chunk_valid`, and data, byte count and flags hold until `chunk_ready`. `chunk_first` carries control bit 3, `chunk_last` carries bit 4, `chunk_sha1` carries bit 2, and `chunk_data` bits [31:0] carry the first window word.
- R5: A result accepted while waiting loads the digest from `res_digest`, adds the chunk's byte count to the count register (0x14) and sets output-ready (control bit 0).
- R6: `irq` is high exactly while output-ready is set and interrupt enable (mask bit 2 at 0x60) is set, and writing 1 to control bit 0 clears output-ready.
- R7: `dma_req` is high while DMA enable (mask bit 3) is set and input-ready is 1.
- R8: A window write while input-ready is 0 is dropped, and it sets a sticky error flag read at status bit 1.
- R9: Writing a length of 0 to the control word ends any partly filled chunk and returns the block to idle, with input-ready at 0.
- R10: When control bit 2 is set, each digest word reads and writes over the bus byte-reversed relative to `ctx_digest`; when the bit is clear, it reads and writes unchanged. Digest and count writes take effect while no chunk is in flight.
- R11: Writing 1 to mask bit 1 clears the digest, count, control, mask, error and window state. Status bit 0 then reads 0 for RST_CYCLES cycles and 1 afterwards.
- R12: The revision register (0x5C) returns REV_MAJOR in bits [7:4] and REV_MINOR in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| chunk_valid | output | 1 | A filled chunk is offered to the engine |
| chunk_ready | input | 1 | Engine takes the chunk |
| chunk_first | output | 1 | Engine should start from standard initial constants |
| chunk_last | output | 1 | Engine should pad and finalise |
| chunk_sha1 | output | 1 | 1 selects SHA-1, 0 selects MD5 |
| chunk_bytes | output | 7 | Byte length of the chunk (1 to 64) |
| chunk_data | output | 512 | Window words, word 0 in the low bits |
| ctx_digest | output | 160 | Current digest context, word 0 in the low bits |
| ctx_count | output | 32 | Bytes processed so far |
| res_valid | input | 1 | Engine result is present |
| res_digest | input | 160 | Engine result digest, word 0 in the low bits |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | DMA request for window data |

## Verification
The bench builds the block with a 16-word window, a five-word digest, a three-cycle soft reset and revision 4.2. The short reset window lets the bench sample both the cycle before the done flag returns and the cycle in which it returns. The full-width window brings the clamp of an over-long length to 64 bytes, and a fill of all sixteen words, within reach. A table of chunk lengths walks single-word, ragged, exact and clamped chunks through a whole message. Directed sequences then cover context save and restore in both byte orders, aborting a chunk with a zero length, dropped writes and the sticky error.

// File: rtl/sham_pkg.sv
package sham_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_WIN  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_REV  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h64;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_FILL = 2'd1,
    SQ_SEND = 2'd2,
    SQ_WAIT = 2'd3
  } seq_state_t;

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/sham_win.sv
module sham_win #(
  parameter int WORDS = 16,
  localparam int PW = $clog2(WORDS + 1),
  localparam int IW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               push,
  input  logic [31:0]        push_data,
  output logic [PW-1:0]      fill,
  output logic [WORDS*32-1:0] data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (clear) begin
      fill <= '0;
    end else if (push) begin
      mem[fill[IW-1:0]] <= push_data;
      fill <= fill + 1'b1;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign data[g*32 +: 32] = mem[g];
  end
endmodule

// File: rtl/sham_seq.sv
module sham_seq import sham_pkg::*; #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          arm,
  input  logic          stop,
  input  logic [PW-1:0] fill,
  input  logic [PW-1:0] need,
  input  logic          chunk_ready,
  input  logic          res_valid,
  output logic          in_ready,
  output logic          chunk_valid,
  output logic          done,
  output logic          open,
  output logic          wait_st
);
  seq_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE: if (arm) st_nx = SQ_FILL;
      SQ_FILL: begin
        if (stop) st_nx = SQ_IDLE;
        else if (arm) st_nx = SQ_FILL;
        else if (fill >= need) st_nx = SQ_SEND;
      end
      SQ_SEND: if (chunk_ready) st_nx = SQ_WAIT;
      SQ_WAIT: if (res_valid) st_nx = SQ_IDLE;
      default: st_nx = SQ_IDLE;
    endcase
    if (srst) st_nx = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else st <= st_nx;
  end

  assign in_ready    = (st == SQ_FILL) && (fill < need);
  assign chunk_valid = (st == SQ_SEND);
  assign wait_st     = (st == SQ_WAIT);
  assign done        = wait_st && res_valid;
  assign open        = (st == SQ_IDLE) || (st == SQ_FILL);
endmodule

// File: rtl/sham_ctx.sv
module sham_ctx #(
  parameter int DIG_WORDS = 5,
  localparam int IXW = $clog2(DIG_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    srst,
  input  logic                    wr_dig,
  input  logic [IXW-1:0]          dig_idx,
  input  logic [31:0]             dig_wdata,
  input  logic                    wr_cnt,
  input  logic [31:0]             cnt_wdata,
  input  logic                    done,
  input  logic [DIG_WORDS*32-1:0] res_digest,
  input  logic [31:0]             add_bytes,
  output logic [DIG_WORDS*32-1:0] digest,
  output logic [31:0]             count
);
  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) digest[g*32 +: 32] <= '0;
      else if (srst) digest[g*32 +: 32] <= '0;
      else if (done) digest[g*32 +: 32] <= res_digest[g*32 +: 32];
      else if (wr_dig && dig_idx == IXW'(g)) digest[g*32 +: 32] <= dig_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (srst) count <= '0;
    else if (done) count <= count + add_bytes;
    else if (wr_cnt) count <= cnt_wdata;
  end
endmodule

// File: rtl/sham_regs.sv
module sham_regs import sham_pkg::*; #(
  parameter int WIN_WORDS  = 16,
  parameter int DIG_WORDS  = 5,
  parameter int RST_CYCLES = 4,
  parameter int REV_MAJOR  = 1,
  parameter int REV_MINOR  = 0,
  localparam int WIN_BYTES = WIN_WORDS * 4,
  localparam int BW  = $clog2(WIN_BYTES + 1),
  localparam int PW  = $clog2(WIN_WORDS + 1),
  localparam int IXW = $clog2(DIG_WORDS),
  localparam int RCW = $clog2(RST_CYCLES + 1),
  localparam int LENW = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    chunk_valid,
  input  logic                    chunk_ready,
  output logic                    chunk_first,
  output logic                    chunk_last,
  output logic                    chunk_sha1,
  output logic [BW-1:0]           chunk_bytes,
  output logic [WIN_WORDS*32-1:0] chunk_data,
  output logic [DIG_WORDS*32-1:0] ctx_digest,
  output logic [31:0]             ctx_count,
  input  logic                    res_valid,
  input  logic [DIG_WORDS*32-1:0] res_digest,
  output logic                    irq,
  output logic                    dma_req
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(int'(OFF_WIN) + (WIN_WORDS - 1) * 4);

  // address decode
  logic aligned, hit_dig, hit_cnt, hit_ctrl, hit_win, hit_rev, hit_mask, hit_stat;
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign hit_dig  = aligned && (bus_addr < ADDR_W'(DIG_WORDS * 4));
  assign hit_cnt  = (bus_addr == OFF_CNT);
  assign hit_ctrl = (bus_addr == OFF_CTRL);
  assign hit_win  = aligned && (bus_addr >= OFF_WIN) && (bus_addr <= WIN_END);
  assign hit_rev  = (bus_addr == OFF_REV);
  assign hit_mask = (bus_addr == OFF_MASK);
  assign hit_stat = (bus_addr == OFF_STAT);

  logic [IXW-1:0] dig_idx;
  assign dig_idx = bus_addr[IXW+1:2];

  // control, mask and status state
  logic [LENW-1:0] len_q;
  logic close_q, const_q, sha1_q, out_rdy_q;
  logic dma_en_q, ie_q, idle_q, err_q;
  logic [RCW-1:0] rst_cnt_q;
  logic rst_done;

  logic srst, in_ready, seq_open, done, wait_st;
  logic wr_ctrl, arm, stop, win_push, win_drop;
  logic [PW-1:0] fill, need_w;
  logic [BW-1:0] bytes_eff;

  assign srst     = bus_we && hit_mask && bus_wdata[1];
  assign wr_ctrl  = bus_we && hit_ctrl && !srst;
  assign arm      = wr_ctrl && seq_open && (bus_wdata[31:5] != '0);
  assign stop     = wr_ctrl && seq_open && (bus_wdata[31:5] == '0);
  assign win_push = bus_we && hit_win && in_ready;
  assign win_drop = bus_we && hit_win && !in_ready;
  assign rst_done = (rst_cnt_q == '0);

  always_comb begin
    if (len_q >= LENW'(WIN_BYTES)) begin
      bytes_eff = BW'(WIN_BYTES);
      need_w    = PW'(WIN_WORDS);
    end else begin
      bytes_eff = BW'(len_q);
      need_w    = PW'((len_q + LENW'(3)) >> 2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; close_q <= 1'b0; const_q <= 1'b0; sha1_q <= 1'b0;
    end else if (srst) begin
      len_q <= '0; close_q <= 1'b0; const_q <= 1'b0; sha1_q <= 1'b0;
    end else if (wr_ctrl && seq_open) begin
      len_q   <= bus_wdata[31:5];
      close_q <= bus_wdata[4];
      const_q <= bus_wdata[3];
      sha1_q  <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_rdy_q <= 1'b0;
    else if (srst) out_rdy_q <= 1'b0;
    else if (done) out_rdy_q <= 1'b1;
    else if (wr_ctrl && bus_wdata[0]) out_rdy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en_q <= 1'b0; ie_q <= 1'b0; idle_q <= 1'b0;
    end else if (srst) begin
      dma_en_q <= 1'b0; ie_q <= 1'b0; idle_q <= 1'b0;
    end else if (bus_we && hit_mask) begin
      dma_en_q <= bus_wdata[3];
      ie_q     <= bus_wdata[2];
      idle_q   <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (srst) err_q <= 1'b0;
    else if (win_drop) err_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_cnt_q <= '0;
    else if (srst) rst_cnt_q <= RCW'(RST_CYCLES);
    else if (!rst_done) rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  // submodules
  sham_win #(.WORDS(WIN_WORDS)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(srst || arm), .push(win_push),
    .push_data(bus_wdata), .fill(fill), .data(chunk_data)
  );

  sham_seq #(.PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .srst(srst), .arm(arm), .stop(stop),
    .fill(fill), .need(need_w), .chunk_ready(chunk_ready), .res_valid(res_valid),
    .in_ready(in_ready), .chunk_valid(chunk_valid), .done(done),
    .open(seq_open), .wait_st(wait_st)
  );

  sham_ctx #(.DIG_WORDS(DIG_WORDS)) u_ctx (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .wr_dig(bus_we && hit_dig && seq_open), .dig_idx(dig_idx),
    .dig_wdata(sha1_q ? swap_bytes(bus_wdata) : bus_wdata),
    .wr_cnt(bus_we && hit_cnt && seq_open), .cnt_wdata(bus_wdata),
    .done(done), .res_digest(res_digest), .add_bytes(32'(bytes_eff)),
    .digest(ctx_digest), .count(ctx_count)
  );

  assign chunk_first = const_q;
  assign chunk_last  = close_q;
  assign chunk_sha1  = sha1_q;
  assign chunk_bytes = bytes_eff;
  assign irq         = out_rdy_q && ie_q;
  assign dma_req     = dma_en_q && in_ready;

  // read mux
  logic [31:0] dig_word;
  assign dig_word = ctx_digest[int'(dig_idx)*32 +: 32];

  always_comb begin
    bus_rdata = '0;
    if (hit_dig)       bus_rdata = sha1_q ? swap_bytes(dig_word) : dig_word;
    else if (hit_cnt)  bus_rdata = ctx_count;
    else if (hit_ctrl) bus_rdata = {len_q, close_q, const_q, sha1_q, in_ready, out_rdy_q};
    else if (hit_rev)  bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
    else if (hit_mask) bus_rdata = {28'd0, dma_en_q, ie_q, !rst_done, idle_q};
    else if (hit_stat) bus_rdata = {30'd0, err_q, rst_done};
  end
endmodule

// File: rtl/sham_regs_chk.sv
module sham_regs_chk #(
  parameter int DATA_W = 512,
  parameter int BW = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chunk_valid,
  input logic              chunk_ready,
  input logic [DATA_W-1:0] chunk_data,
  input logic [BW-1:0]     chunk_bytes,
  input logic              res_valid,
  input logic              wait_st,
  input logic [31:0]       ctx_count,
  input logic              in_ready,
  input logic              dma_req,
  input logic              irq,
  input logic              out_ready,
  input logic              srst,
  input logic              win_drop,
  input logic              err_flag
);
  assert_chunk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && !chunk_ready && !srst |=> chunk_valid && $stable(chunk_data) && $stable(chunk_bytes));

  assert_count_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && wait_st && !srst |=> ctx_count == $past(ctx_count) + 32'($past(chunk_bytes)));

  assert_outrdy_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> $past(res_valid && wait_st));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_ready);

  assert_dma_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> in_ready && !chunk_valid);

  assert_drop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_drop && !srst |=> err_flag);

  assert_srst_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> ctx_count == 32'd0 && !out_ready && !in_ready && !err_flag);
endmodule

bind sham_regs sham_regs_chk #(.DATA_W(WIN_WORDS * 32), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
  .chunk_data(chunk_data), .chunk_bytes(chunk_bytes), .res_valid(res_valid),
  .wait_st(wait_st), .ctx_count(ctx_count), .in_ready(in_ready), .dma_req(dma_req),
  .irq(irq), .out_ready(out_rdy_q), .srst(srst), .win_drop(win_drop), .err_flag(err_q)
);

// File: tb/tb_sham_regs.sv
module tb_sham_regs;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 3;
  localparam logic [7:0] A_CNT = 8'h14, A_CTRL = 8'h18, A_WIN = 8'h1C,
                         A_REV = 8'h5C, A_MASK = 8'h60, A_STAT = 8'h64;
  // length, expected words, expected bytes
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{'{1,1,1}, '{4,1,4}, '{5,2,5}, '{8,2,8}, '{63,16,63}, '{100,16,64}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic chunk_valid, chunk_ready = 1'b0, chunk_first, chunk_last, chunk_sha1;
  logic [6:0] chunk_bytes;
  logic [511:0] chunk_data;
  logic [159:0] ctx_digest, res_digest = '0;
  logic [31:0] ctx_count;
  logic res_valid = 1'b0, irq, dma_req;

  int total = 0, bad = 0;
  logic rec_seen = 1'b0, rec_first, rec_last, rec_sha1;
  logic [6:0] rec_bytes;
  logic [31:0] rec_w0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sham_regs #(.WIN_WORDS(16), .DIG_WORDS(5), .RST_CYCLES(RST_CYC),
              .REV_MAJOR(4), .REV_MINOR(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chunk_valid(chunk_valid),
    .chunk_ready(chunk_ready), .chunk_first(chunk_first), .chunk_last(chunk_last),
    .chunk_sha1(chunk_sha1), .chunk_bytes(chunk_bytes), .chunk_data(chunk_data),
    .ctx_digest(ctx_digest), .ctx_count(ctx_count), .res_valid(res_valid),
    .res_digest(res_digest), .irq(irq), .dma_req(dma_req)
  );

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // engine stand-in
  initial begin
    forever begin
      @(negedge clk);
      if (chunk_valid) begin
        rec_bytes = chunk_bytes; rec_first = chunk_first; rec_last = chunk_last;
        rec_sha1 = chunk_sha1; rec_w0 = chunk_data[31:0]; rec_seen = 1'b1;
        @(negedge clk); chunk_ready = 1'b1;
        @(negedge clk); chunk_ready = 1'b0;
        repeat (2) @(negedge clk);
        res_digest = {5{32'hC0DE0000 | 32'(rec_bytes)}};
        res_valid = 1'b1;
        @(negedge clk); res_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int sum;
    sum = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 revision
    rd(A_CTRL, d); chk(d == 32'd0, "R1 ctrl", d, 32'd0);
    rd(A_CNT, d);  chk(d == 32'd0, "R1 count", d, 32'd0);
    rd(8'h00, d);  chk(d == 32'd0, "R1 digest", d, 32'd0);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R1 status done", d, 32'd1);
    rd(A_REV, d);  chk(d == 32'h42, "R12 revision", d, 32'h42);

    wr(A_MASK, 32'h4);  // interrupt enable
    for (int i = 0; i < NV; i++) begin
      logic [31:0] cw;
      cw = (32'(VEC[i][0]) << 5) | (32'(i == NV-1) << 4) | (32'(i == 0) << 3) | 32'h4;
      rec_seen = 1'b0;
      wr(A_CTRL, cw);
      for (int w = 0; w < VEC[i][1]; w++) begin
        if (w == VEC[i][1] - 1) begin
          rd(A_CTRL, d); chk(d[1] == 1'b1, "R3 in_ready before last word", d, 32'd1);
        end
        wr(A_WIN, 32'hA0000000 + 32'(i * 256 + w));
      end
      rd(A_CTRL, d); chk(d[1] == 1'b0, "R3 in_ready after last word", d, 32'd0);
      for (int k = 0; k < 20 && !rec_seen; k++) @(negedge clk);
      chk(rec_seen, "R4 chunk offered", 32'(rec_seen), 32'd1);
      chk(rec_bytes == 7'(VEC[i][2]), "R3 chunk bytes", 32'(rec_bytes), 32'(VEC[i][2]));
      chk(rec_first == (i == 0) && rec_last == (i == NV-1) && rec_sha1,
          "R4 chunk flags", {29'd0, rec_first, rec_last, rec_sha1},
          {29'd0, 1'(i == 0), 1'(i == NV-1), 1'b1});
      chk(rec_w0 == 32'hA0000000 + 32'(i * 256), "R4 chunk word0", rec_w0, 32'hA0000000 + 32'(i * 256));
      d = 32'd0;
      for (int k = 0; k < 30 && !d[0]; k++) begin @(negedge clk); rd(A_CTRL, d); end
      chk(d[0] == 1'b1, "R5 output-ready", d, 32'd1);
      chk(irq == 1'b1, "R6 irq raised", 32'(irq), 32'd1);
      sum += VEC[i][2];
      rd(A_CNT, d); chk(d == 32'(sum), "R5 count", d, 32'(sum));
      rd(8'h00, d);
      chk(d == bsw(32'hC0DE0000 | 32'(VEC[i][2])), "R10 digest sha1 view", d, bsw(32'hC0DE0000 | 32'(VEC[i][2])));
      wr(A_CTRL, 32'h5);  // clear output-ready, length 0
      chk(irq == 1'b0, "R6 irq cleared", 32'(irq), 32'd0);
    end

    // R7 dma request, R9 zero length abort
    wr(A_MASK, 32'hC);
    wr(A_CTRL, (32'd8 << 5) | 32'h4);
    chk(dma_req == 1'b1, "R7 dma_req armed", 32'(dma_req), 32'd1);
    wr(A_WIN, 32'h12345678);
    chk(dma_req == 1'b1, "R7 dma_req partial", 32'(dma_req), 32'd1);
    wr(A_CTRL, 32'h4);
    rd(A_CTRL, d); chk(d[1] == 1'b0, "R9 idle after zero length", d, 32'd0);
    chk(dma_req == 1'b0, "R7 dma_req dropped", 32'(dma_req), 32'd0);

    // R8 dropped write and sticky error
    rd(A_STAT, d); chk(d[1] == 1'b0, "R8 no error yet", d, 32'd1);
    wr(A_WIN, 32'hDEADBEEF);
    rd(A_STAT, d); chk(d[1] == 1'b1, "R8 sticky error", d, 32'd3);
    chk(chunk_valid == 1'b0, "R8 no chunk from dropped write", 32'(chunk_valid), 32'd0);

    // R10 endianness and context restore
    wr(8'h00, 32'h11223344);
    chk(ctx_digest[31:0] == 32'h44332211, "R10 sha1 stored order", ctx_digest[31:0], 32'h44332211);
    rd(8'h00, d); chk(d == 32'h11223344, "R10 sha1 readback", d, 32'h11223344);
    wr(A_CTRL, 32'h0);
    rd(8'h00, d); chk(d == 32'h44332211, "R10 md5 view", d, 32'h44332211);
    wr(8'h04, 32'hAABBCCDD);
    chk(ctx_digest[63:32] == 32'hAABBCCDD, "R10 md5 stored order", ctx_digest[63:32], 32'hAABBCCDD);
    wr(A_CNT, 32'h1000);
    rd(A_CNT, d); chk(d == 32'h1000 && ctx_count == 32'h1000, "R10 count restore", d, 32'h1000);

    // R2 undefined offsets
    wr(8'h70, 32'hFFFFFFFF);
    rd(8'h70, d); chk(d == 32'd0, "R2 undefined read", d, 32'd0);
    rd(8'h02, d); chk(d == 32'd0, "R2 unaligned read", d, 32'd0);
    rd(A_CNT, d); chk(d == 32'h1000, "R2 write ignored", d, 32'h1000);

    // R11 soft reset
    wr(A_MASK, 32'h2);
    rd(A_STAT, d); chk(d[0] == 1'b0, "R11 reset in progress", d, 32'd0);
    repeat (RST_CYC - 1) @(negedge clk);
    rd(A_STAT, d); chk(d[0] == 1'b0, "R11 still resetting", d, 32'd0);
    @(negedge clk);
    rd(A_STAT, d); chk(d == 32'd1, "R11 reset done, error cleared", d, 32'd1);
    rd(A_CNT, d); chk(d == 32'd0, "R11 count cleared", d, 32'd0);
    rd(8'h04, d); chk(d == 32'd0, "R11 digest cleared", d, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule